// File: doc/BRIEF.md
# Dual-Bank Selectable Clock Divider

This block divides one source clock into two banks of four output lanes each. The source is picked by plain selection logic: a free-running oscillator clock, or one of two reference clocks. Each bank has its own 2-bit ratio code and its own table of even divide ratios, so the two banks can run at related but different frequencies from the same edges.

A single hold input does two jobs. It clears both divider counters and it switches all eight lanes to high impedance. When it is released, both banks start counting on the same source edge. This keeps their rising edges aligned. A change of ratio code is taken up only when the bank's current output period ends, so a change never produces a runt pulse.

Top module: `dual_bank_clkdiv`

## Requirements
- R1: Bank A divides the selected source by 2, 4, 6 or 8 for ratio codes 00, 01, 10 and 11. The output is high for exactly half the ratio in source cycles and low for the other half, and each period starts with the high half.
- R2: Bank B divides the selected source by 4, 6, 8 or 12 for ratio codes 00, 01, 10 and 11, with the same exact 50% duty cycle and high-first period.
- R3: While hold_hiz is high, all eight lanes are high impedance and both divider counters are held cleared, whatever the other controls are.
- R4: After hold_hiz falls, both banks read low until the first rising edge of the selected source. On that edge both banks go high together.
- R5: With use_osc high, the dividers are clocked by osc_clk. With use_osc low, they are clocked by the reference that ref_sel picks.
- R6: ref_sel low picks ref0_clk and ref_sel high picks ref1_clk.
- R7: All four lanes of a bank always carry the same value.
- R8: A ratio code is sampled on the source edge that starts a new output period (the first edge after release, and each edge where the period ends). A code change in the middle of a period leaves that period at its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator source clock |
| ref0_clk | input | 1 | Reference clock 0 |
| ref1_clk | input | 1 | Reference clock 1 |
| use_osc | input | 1 | 1: oscillator source, 0: reference source |
| ref_sel | input | 1 | 0: ref0_clk, 1: ref1_clk |
| hold_hiz | input | 1 | 1: clear dividers, lanes high impedance |
| ratio_sel_a | input | 2 | Bank A ratio code |
| ratio_sel_b | input | 2 | Bank B ratio code |
| bank_a_o | output | 4 | Bank A clock lanes |
| bank_b_o | output | 4 | Bank B clock lanes |

## Verification
Each lane is one register behind the selected source. Its new value is therefore due right after each rising source edge. The bench waits for that edge in its own copy of the source selection and samples 1 ns later, always before the next edge. High impedance follows hold_hiz without any register. It is checked 2 ns after the bench drives two opposite patterns onto the lanes: a disabled lane lets each pattern through unchanged. A ratio code written just after the sample at edge k can only affect edge k+1 or later. The bench's period model therefore takes up a new code only at the edge where its own period count wraps.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

    typedef logic [1:0] ratio_sel_t;

    // Map a 2-bit ratio code onto one of four table entries.
    function automatic int unsigned pick_ratio(
        input ratio_sel_t  code,
        input int unsigned r0,
        input int unsigned r1,
        input int unsigned r2,
        input int unsigned r3
    );
        case (code)
            2'b00:   return r0;
            2'b01:   return r1;
            2'b10:   return r2;
            default: return r3;
        endcase
    endfunction

endpackage

// File: rtl/clk_src_mux.sv
`timescale 1ns/1ps
module clk_src_mux (
    input  logic osc_clk,
    input  logic ref0_clk,
    input  logic ref1_clk,
    input  logic use_osc,
    input  logic ref_sel,
    output logic src_clk
);

    logic ref_clk;

    always_comb begin
        ref_clk = ref_sel ? ref1_clk : ref0_clk;
        src_clk = use_osc ? osc_clk : ref_clk;
    end

endmodule

// File: rtl/bank_divider.sv
`timescale 1ns/1ps
module bank_divider #(
    parameter int unsigned R0 = 2,
    parameter int unsigned R1 = 4,
    parameter int unsigned R2 = 6,
    parameter int unsigned R3 = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  clkdiv_pkg::ratio_sel_t  ratio_sel,
    output logic                    div_clk
);

    localparam int unsigned MAX01 = (R0 > R1) ? R0 : R1;
    localparam int unsigned MAX23 = (R2 > R3) ? R2 : R3;
    localparam int unsigned MAX_R = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int          CNT_W = $clog2(MAX_R + 1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] ratio;
        logic             out;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [CNT_W-1:0] ratio_req;

    always_comb begin
        ratio_req = CNT_W'(clkdiv_pkg::pick_ratio(ratio_sel, R0, R1, R2, R3));
        st_d = st_q;
        if (!st_q.run) begin
            // first edge after release: period starts here
            st_d.run   = 1'b1;
            st_d.cnt   = '0;
            st_d.ratio = ratio_req;
        end else if (st_q.cnt == st_q.ratio - CNT_W'(1)) begin
            // period ends: new ratio code taken up only here
            st_d.cnt   = '0;
            st_d.ratio = ratio_req;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        st_d.out = (st_d.cnt < (st_d.ratio >> 1));
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_clk = st_q.out;

endmodule

// File: rtl/lane_driver.sv
`timescale 1ns/1ps
module lane_driver #(
    parameter int N_LANES = 4
) (
    input  logic               clk_i,
    input  logic               hiz_i,
    output wire [N_LANES-1:0]  lanes_o
);

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        assign lanes_o[g] = hiz_i ? 1'bz : clk_i;
    end

endmodule

// File: rtl/dual_bank_clkdiv.sv
`timescale 1ns/1ps
module dual_bank_clkdiv #(
    parameter int          N_LANES = 4,
    parameter int unsigned A_R0    = 2,
    parameter int unsigned A_R1    = 4,
    parameter int unsigned A_R2    = 6,
    parameter int unsigned A_R3    = 8,
    parameter int unsigned B_R0    = 4,
    parameter int unsigned B_R1    = 6,
    parameter int unsigned B_R2    = 8,
    parameter int unsigned B_R3    = 12
) (
    input  logic               osc_clk,
    input  logic               ref0_clk,
    input  logic               ref1_clk,
    input  logic               use_osc,
    input  logic               ref_sel,
    input  logic               hold_hiz,
    input  logic [1:0]         ratio_sel_a,
    input  logic [1:0]         ratio_sel_b,
    output wire [N_LANES-1:0]  bank_a_o,
    output wire [N_LANES-1:0]  bank_b_o
);

    logic src_clk;
    logic a_clk;
    logic b_clk;

    clk_src_mux i_src (
        .osc_clk  (osc_clk),
        .ref0_clk (ref0_clk),
        .ref1_clk (ref1_clk),
        .use_osc  (use_osc),
        .ref_sel  (ref_sel),
        .src_clk  (src_clk)
    );

    bank_divider #(.R0(A_R0), .R1(A_R1), .R2(A_R2), .R3(A_R3)) i_div_a (
        .clk       (src_clk),
        .rst       (hold_hiz),
        .ratio_sel (ratio_sel_a),
        .div_clk   (a_clk)
    );

    bank_divider #(.R0(B_R0), .R1(B_R1), .R2(B_R2), .R3(B_R3)) i_div_b (
        .clk       (src_clk),
        .rst       (hold_hiz),
        .ratio_sel (ratio_sel_b),
        .div_clk   (b_clk)
    );

    lane_driver #(.N_LANES(N_LANES)) i_drv_a (
        .clk_i   (a_clk),
        .hiz_i   (hold_hiz),
        .lanes_o (bank_a_o)
    );

    lane_driver #(.N_LANES(N_LANES)) i_drv_b (
        .clk_i   (b_clk),
        .hiz_i   (hold_hiz),
        .lanes_o (bank_b_o)
    );

endmodule

// File: rtl/dual_bank_clkdiv_chk.sv
`timescale 1ns/1ps
module dual_bank_clkdiv_chk #(
    parameter int RUN_W = 8
) (
    input logic src_clk,
    input logic hold,
    input logic a_clk,
    input logic b_clk
);

    logic             a_last_q, a_have_q, b_last_q, b_have_q;
    logic [RUN_W-1:0] a_run_q, a_hi_q, b_run_q, b_hi_q;

    always_ff @(posedge src_clk or posedge hold) begin
        if (hold) begin
            a_last_q <= 1'b0;
            a_have_q <= 1'b0;
            a_run_q  <= '0;
            a_hi_q   <= '0;
            b_last_q <= 1'b0;
            b_have_q <= 1'b0;
            b_run_q  <= '0;
            b_hi_q   <= '0;
        end else begin
            a_last_q <= a_clk;
            a_run_q  <= (a_clk != a_last_q) ? RUN_W'(1) : a_run_q + RUN_W'(1);
            if (!a_clk && a_last_q) begin
                a_hi_q   <= a_run_q;
                a_have_q <= 1'b1;
            end
            b_last_q <= b_clk;
            b_run_q  <= (b_clk != b_last_q) ? RUN_W'(1) : b_run_q + RUN_W'(1);
            if (!b_clk && b_last_q) begin
                b_hi_q   <= b_run_q;
                b_have_q <= 1'b1;
            end
        end
    end

    AST_HELD_IN_HOLD: assert property (@(posedge src_clk) hold |-> (!a_clk && !b_clk)); // R3
    AST_FIRST_EDGE_ALIGNED: assert property (@(posedge src_clk) disable iff (hold) $past(hold) |=> (a_clk && b_clk)); // R4
    AST_A_EVEN_DUTY: assert property (@(posedge src_clk) disable iff (hold) (a_clk && !a_last_q && a_have_q) |-> (a_run_q == a_hi_q)); // R1
    AST_B_EVEN_DUTY: assert property (@(posedge src_clk) disable iff (hold) (b_clk && !b_last_q && b_have_q) |-> (b_run_q == b_hi_q)); // R2

endmodule

bind dual_bank_clkdiv dual_bank_clkdiv_chk i_chk (
    .src_clk (src_clk),
    .hold    (hold_hiz),
    .a_clk   (a_clk),
    .b_clk   (b_clk)
);

// File: tb/test_dual_bank_clkdiv.sv
`timescale 1ns/1ps
module test_dual_bank_clkdiv;

    logic osc_clk  = 1'b0;
    logic ref0_clk = 1'b0;
    logic ref1_clk = 1'b0;
    always #10 osc_clk  = ~osc_clk;   // 50 MHz
    always #15 ref0_clk = ~ref0_clk;
    always #22 ref1_clk = ~ref1_clk;

    logic       hold_hiz = 1'b0;
    logic       use_osc  = 1'b1;
    logic       ref_sel  = 1'b0;
    logic [1:0] sel_a    = 2'b00;
    logic [1:0] sel_b    = 2'b00;
    logic       tb_en    = 1'b0;
    logic [3:0] tb_val   = 4'h0;
    wire  [3:0] qa;
    wire  [3:0] qb;

    assign qa = tb_en ? tb_val : 4'bzzzz;
    assign qb = tb_en ? tb_val : 4'bzzzz;

    dual_bank_clkdiv i_dual_bank_clkdiv (
        .osc_clk     (osc_clk),
        .ref0_clk    (ref0_clk),
        .ref1_clk    (ref1_clk),
        .use_osc     (use_osc),
        .ref_sel     (ref_sel),
        .hold_hiz    (hold_hiz),
        .ratio_sel_a (sel_a),
        .ratio_sel_b (sel_b),
        .bank_a_o    (qa),
        .bank_b_o    (qb)
    );

    int          checks   = 0;
    int          failures = 0;
    int unsigned cyc      = 0;
    bit          done     = 1'b0;

    always @(posedge osc_clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ratio_a(input logic [1:0] s);
        case (s)
            2'b00:   return 2;
            2'b01:   return 4;
            2'b10:   return 6;
            default: return 8;
        endcase
    endfunction

    function automatic int ratio_b(input logic [1:0] s);
        case (s)
            2'b00:   return 4;
            2'b01:   return 6;
            2'b10:   return 8;
            default: return 12;
        endcase
    endfunction

    task automatic wait_src(input bit byp, input bit rs);
        if (byp)     @(posedge osc_clk);
        else if (rs) @(posedge ref1_clk);
        else         @(posedge ref0_clk);
    endtask

    // One run: hold, check high impedance, release, follow NS source edges.
    task automatic run_case(input bit byp, input bit rs, input logic [1:0] sa, input logic [1:0] sb,
                            input int ns, input int chg_at, input logic [1:0] sa2,
                            input logic [1:0] sb2, input string tag);
        int pa, pb, rna, rnb, ma, mb, lanes_bad;
        bit ea, eb;
        hold_hiz = 1'b1;
        use_osc  = byp;
        ref_sel  = rs;
        sel_a    = sa;
        sel_b    = sb;
        #3;
        // R3: a disabled lane passes the bench pattern through untouched
        tb_en  = 1'b1;
        tb_val = 4'b0101;
        #2;
        chk(qa == 4'b0101 && qb == 4'b0101, {"R3 hiz ", tag}, int'({qa, qb}), 8'h55);
        tb_val = 4'b1010;
        #2;
        chk(qa == 4'b1010 && qb == 4'b1010, {"R3 hiz ", tag}, int'({qa, qb}), 8'hAA);
        tb_en = 1'b0;
        wait_src(byp, rs);
        #1 hold_hiz = 1'b0;
        #1;
        chk(qa == 4'h0 && qb == 4'h0, {"R4 low before first edge ", tag}, int'({qa, qb}), 0);
        pa = 0; pb = 0; rna = 0; rnb = 0; ma = 0; mb = 0; lanes_bad = 0;
        for (int k = 0; k < ns; k++) begin
            wait_src(byp, rs);
            if (k == 0) begin
                pa = 0; rna = ratio_a(sel_a);
                pb = 0; rnb = ratio_b(sel_b);
            end else begin
                pa++;
                if (pa == rna) begin pa = 0; rna = ratio_a(sel_a); end
                pb++;
                if (pb == rnb) begin pb = 0; rnb = ratio_b(sel_b); end
            end
            ea = (pa < rna / 2);
            eb = (pb < rnb / 2);
            #1;
            if (k == 0)
                chk(qa == 4'hF && qb == 4'hF, {"R4 aligned first rise ", tag}, int'({qa, qb}), 8'hFF);
            if (qa != {4{ea}}) ma++;
            if (qb != {4{eb}}) mb++;
            if ((qa != 4'h0 && qa != 4'hF) || (qb != 4'h0 && qb != 4'hF)) lanes_bad++;
            if (k == chg_at) begin
                sel_a = sa2;
                sel_b = sb2;
            end
        end
        chk(ma == 0, {"R1 R8 bank A pattern ", tag}, ma, 0);
        chk(mb == 0, {"R2 R8 bank B pattern ", tag}, mb, 0);
        chk(lanes_bad == 0, {"R7 lanes equal ", tag}, lanes_bad, 0);
        hold_hiz = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        #1 hold_hiz = 1'b1;
        #5;
        // all 16 code pairs from the oscillator
        for (int i = 0; i < 16; i++)
            run_case(1'b1, 1'b0, 2'(i >> 2), 2'(i), 48, -1, 2'b00, 2'b00, "R5 osc combo");
        // reference paths, ref_sel low then high
        for (int i = 0; i < 4; i++)
            run_case(1'b0, 1'b0, 2'(i), 2'(3 - i), 40, -1, 2'b00, 2'b00, "R5 R6 ref0");
        for (int i = 0; i < 4; i++)
            run_case(1'b0, 1'b1, 2'(i), 2'(i), 40, -1, 2'b00, 2'b00, "R5 R6 ref1");
        // R8 directed: long period cut short mid-period must still finish
        run_case(1'b1, 1'b0, 2'b11, 2'b00, 40, 2, 2'b00, 2'b11, "R8 mid-period change");
        run_case(1'b1, 1'b0, 2'b00, 2'b11, 48, 5, 2'b11, 2'b00, "R8 change before wrap");
        // constrained random controls and mid-run changes
        for (int n = 0; n < 20; n++) begin
            logic [1:0] a1, b1, a2, b2;
            bit byp, rs;
            a1  = 2'($urandom_range(3));
            b1  = 2'($urandom_range(3));
            a2  = 2'($urandom_range(3));
            b2  = 2'($urandom_range(3));
            byp = 1'($urandom_range(1));
            rs  = 1'($urandom_range(1));
            run_case(byp, rs, a1, b1, 48, int'($urandom_range(40)), a2, b2, "random R5 R6");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cyc >= 150000 || done);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule